// File: doc/BRIEF.md
# NAND Chunk Hamming Check-Code Generator

This block computes the 24-bit Hamming check code that protects one 256-byte chunk of NAND page data. The code corrects any single flipped bit and detects any pair of flipped bits. Data arrives one byte per clock on `data_i`, qualified by `valid_i`. A `start_i` strobe opens a new chunk. Two accumulators run side by side. The column accumulator folds each byte's bits into three complementary pairs of parities, selected by bit position within the byte. The row accumulator folds each byte's overall parity into one complementary pair for each bit of the byte's position in the chunk. When the final byte is accepted, `done_o` pulses and `ecc_o` carries the finished code. The code stays valid until the next start.

A small controller sequences the work. Its states are:

- `ST_IDLE`: after reset, before any start.
- `ST_ACCUM`: collecting bytes.
- `ST_DONE`: the code is complete and held.

Its transitions are:

- IDLE→ACCUM on start.
- ACCUM→ACCUM on a start in mid-chunk, which restarts the chunk.
- ACCUM→DONE when the last byte is accepted.
- DONE→ACCUM on start.

The parameter `IDX_W` sets the width of the byte index. The chunk is 2^IDX_W bytes long, and the default is 8.

Top module: `nand_ecc_gen`

## Requirements
- R1: `done_o` is high for exactly one cycle: the cycle that follows the clock edge accepting byte 255 of a chunk. It is low at every other time.
- R2: `ecc_o[23:18]` hold six column parities, accumulated over every accepted byte of the chunk. From bit 23 down to bit 18 they are: XOR of byte bits {7,6,5,4}; {3,2,1,0}; {7,6,3,2}; {5,4,1,0}; {7,5,3,1}; {6,4,2,0}.
- R3: For index bit k (0..7), `ecc_o[2k+1]` is the XOR of the parities of all bytes whose position in the chunk has bit k set. `ecc_o[2k]` is the same XOR over the bytes whose position has bit k clear. As an example, a chunk holding 0x01 at position 0 and zeros elsewhere gives `ecc_o` = 0x575555.
- R4: `ecc_o[17:16]` are always 1.
- R5: After reset, `ecc_o` = 0x030000 and `done_o` = 0. A start clears both accumulators and the byte counter. A byte presented with `valid_i` in the start cycle becomes byte 0 of the new chunk.
- R6: A byte is ignored, with no effect on `ecc_o` or `done_o`, in three cases: `valid_i` is low; it arrives before the first start; it arrives after a chunk completes and before the next start.
- R7: After `done_o`, `ecc_o` holds its value until the next start.
- R8: Flipping one data bit changes exactly one bit of each of the 11 complementary pairs (3 column pairs and 8 row pairs). The XOR of the two codes therefore has exactly 11 ones among its 22 parity bits.
- R9: A start in the middle of a chunk discards the partial chunk. The result is then the code of the bytes that follow that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new chunk, clearing all state |
| valid_i | input | 1 | `data_i` carries a byte this cycle |
| data_i | input | 8 | Data byte |
| done_o | output | 1 | One-cycle pulse when the check code is complete |
| ecc_o | output | 24 | Check code: column parities, two filler ones, row parities |

## Verification
The bench builds the block with its default parameters, a 256-byte chunk with eight row pairs, because the code format is defined at that size. A bench model works bit by bit rather than byte by byte, and predicts the code for fixed and random chunks, including chunks with idle gaps. A sweep flips every bit of the bytes at positions 0, 255 and each power of two. This exercises every row pair in both polarities and every column pair, which brings the 11-of-22 single-error signature of R8 within reach.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_DONE  = 2'd2
    } ecc_state_e;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned COL_PAIRS = 3;
    localparam int unsigned COL_W    = 2 * COL_PAIRS;

    // Mask of the byte bits whose position has bit j equal to hi.
    function automatic logic [BYTE_W-1:0] col_mask(input int j, input bit hi);
        logic [BYTE_W-1:0] m;
        m = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            m[i] = (((i >> j) & 1) == (hi ? 1 : 0));
        end
        return m;
    endfunction

endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
    import nand_ecc_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             valid_i,
    output logic             clear_o,
    output logic             accept_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    ecc_state_e       state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic             done_q;
    logic             last;

    // Next state and handshake decode
    always_comb begin
        clear_o  = start_i;
        accept_o = valid_i && (start_i || (state_q == ST_ACCUM));
        idx_o    = start_i ? '0 : cnt_q;
        last     = accept_o && (idx_o == LAST_IDX);
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_ACCUM;
            ST_ACCUM: begin
                if (last)         state_d = ST_DONE;
                else if (start_i) state_d = ST_ACCUM;
            end
            ST_DONE:  if (start_i) state_d = ST_ACCUM;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Counter and done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last;
            if (accept_o)     cnt_q <= idx_o + 1'b1;
            else if (start_i) cnt_q <= '0;
        end
    end

    assign done_o = done_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R1
    AST_DONE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cnt_q == '0)); // R1
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_o && !start_i) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/nand_ecc_col_acc.sv
module nand_ecc_col_acc
    import nand_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [COL_W-1:0]  col_o
);

    logic [COL_W-1:0] contrib;
    logic [COL_W-1:0] col_q;

    for (genvar j = 0; j < COL_PAIRS; j++) begin : g_pair
        localparam logic [BYTE_W-1:0] HI_M = col_mask(j, 1'b1);
        localparam logic [BYTE_W-1:0] LO_M = col_mask(j, 1'b0);
        assign contrib[2*j+1] = ^(data_i & HI_M);
        assign contrib[2*j]   = ^(data_i & LO_M);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (clr_i || en_i) begin
            col_q <= (clr_i ? '0 : col_q) ^ (en_i ? contrib : '0);
        end
    end

    assign col_o = col_q;

    AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(col_q)); // R6
    AST_COL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !en_i) |=> (col_q == '0)); // R5

endmodule

// File: rtl/nand_ecc_row_acc.sv
module nand_ecc_row_acc
    import nand_ecc_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [IDX_W-1:0]  set_o,
    output logic [IDX_W-1:0]  unset_o
);

    logic             byte_par;
    logic [IDX_W-1:0] set_q, unset_q, set_d, unset_d;

    assign byte_par = ^data_i;

    for (genvar k = 0; k < IDX_W; k++) begin : g_row
        logic hit;
        assign hit        = en_i && byte_par;
        assign set_d[k]   = (clr_i ? 1'b0 : set_q[k])   ^ (hit &&  idx_i[k]);
        assign unset_d[k] = (clr_i ? 1'b0 : unset_q[k]) ^ (hit && !idx_i[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q   <= '0;
            unset_q <= '0;
        end else begin
            set_q   <= set_d;
            unset_q <= unset_d;
        end
    end

    assign set_o   = set_q;
    assign unset_o = unset_q;

    AST_ROW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !en_i) |=> (set_q == '0 && unset_q == '0)); // R5
    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> ($stable(set_q) && $stable(unset_q))); // R6

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
    import nand_ecc_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    localparam int unsigned ROW_W = 2 * IDX_W,
    localparam int unsigned ECC_W = ROW_W + 2 + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              valid_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              done_o,
    output logic [ECC_W-1:0]  ecc_o
);

    logic             clear, accept;
    logic [IDX_W-1:0] idx;
    logic [COL_W-1:0] col;
    logic [IDX_W-1:0] row_set, row_unset;
    logic [ROW_W-1:0] row;

    nand_ecc_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .valid_i  (valid_i),
        .clear_o  (clear),
        .accept_o (accept),
        .idx_o    (idx),
        .done_o   (done_o)
    );

    nand_ecc_col_acc u_col (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clear),
        .en_i   (accept),
        .data_i (data_i),
        .col_o  (col)
    );

    nand_ecc_row_acc #(.IDX_W(IDX_W)) u_row (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clear),
        .en_i    (accept),
        .idx_i   (idx),
        .data_i  (data_i),
        .set_o   (row_set),
        .unset_o (row_unset)
    );

    for (genvar k = 0; k < IDX_W; k++) begin : g_pack
        assign row[2*k+1] = row_set[k];
        assign row[2*k]   = row_unset[k];
    end

    assign ecc_o = {col, 2'b11, row};

    // Every complementary pair XORs to the total parity of the chunk.
    logic [IDX_W+COL_PAIRS-1:0] pair_x;
    for (genvar p = 0; p < IDX_W + COL_PAIRS; p++) begin : g_px
        if (p < IDX_W) begin : g_r
            assign pair_x[p] = row_set[p] ^ row_unset[p];
        end else begin : g_c
            assign pair_x[p] = col[2*(p-IDX_W)+1] ^ col[2*(p-IDX_W)];
        end
    end

    AST_PAIR_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_x == '0) || (&pair_x)); // R8
    AST_HOLD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> $stable(ecc_o)); // R7

endmodule

// File: tb/nand_ecc_gen_bench.sv
module nand_ecc_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        valid_i = 1'b0;
    logic [7:0]  data_i = '0;
    logic        done_o;
    logic [23:0] ecc_o;

    always #5 clk = ~clk;

    nand_ecc_gen u_nand_ecc_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .valid_i (valid_i),
        .data_i  (data_i),
        .done_o  (done_o),
        .ecc_o   (ecc_o)
    );

    logic [7:0] chunk [256];
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Bit-by-bit model: each set data bit toggles one parity of every pair.
    function automatic logic [23:0] model();
        logic [5:0]  c;
        logic [15:0] r;
        c = '0;
        r = '0;
        for (int i = 0; i < 256; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (chunk[i][b]) begin
                    for (int j = 0; j < 3; j++) begin
                        if ((b >> j) & 1) c[2*j+1] = ~c[2*j+1];
                        else              c[2*j]   = ~c[2*j];
                    end
                    for (int k = 0; k < 8; k++) begin
                        if ((i >> k) & 1) r[2*k+1] = ~r[2*k+1];
                        else              r[2*k]   = ~r[2*k];
                    end
                end
            end
        end
        return {c, 2'b11, r};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_code(input logic [23:0] got, input logic [23:0] exp, input string what);
        check(got[23:18] == exp[23:18], "R2", what, 32'(got[23:18]), 32'(exp[23:18]));
        check(got[15:0] == exp[15:0], "R3", what, 32'(got[15:0]), 32'(exp[15:0]));
        check(got[17:16] == 2'b11, "R4", what, 32'(got[17:16]), 32'h3);
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        start_i = 1'b0;
        valid_i = 1'b0;
        data_i  = 8'($urandom);
    endtask

    task automatic feed(input logic [7:0] d, input bit st);
        @(negedge clk);
        start_i = st;
        valid_i = 1'b1;
        data_i  = d;
    endtask

    task automatic run_chunk(input bit gaps, output logic [23:0] got);
        for (int i = 0; i < 256; i++) begin
            if (gaps && ($urandom % 4 == 0)) idle_cycle();
            feed(chunk[i], i == 0);
            if (i == 200) check(done_o == 1'b0, "R1", "done early", 32'(done_o), 0);
        end
        idle_cycle();
        check(done_o == 1'b1, "R1", "done after last byte", 32'(done_o), 1);
        got = ecc_o;
        idle_cycle();
        check(done_o == 1'b0, "R1", "done one cycle", 32'(done_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] got, base, exp, d;
        int pos [10] = '{0, 1, 2, 4, 8, 16, 32, 64, 128, 255};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ecc_o == 24'h030000, "R5", "reset code", 32'(ecc_o), 32'h030000);
        check(done_o == 1'b0, "R5", "reset done", 32'(done_o), 0);

        // R6: bytes before any start are ignored
        for (int i = 0; i < 6; i++) feed(8'hA5 ^ 8'(i), 1'b0);
        idle_cycle();
        check(ecc_o == 24'h030000, "R6", "bytes before start", 32'(ecc_o), 32'h030000);
        check(done_o == 1'b0, "R6", "done before start", 32'(done_o), 0);

        // Known single-bit chunk (R3 example)
        foreach (chunk[i]) chunk[i] = 8'h00;
        chunk[0] = 8'h01;
        run_chunk(1'b0, got);
        check(got == 24'h575555, "R3", "single bit at byte 0", 32'(got), 32'h575555);

        foreach (chunk[i]) chunk[i] = 8'h00;
        run_chunk(1'b0, got);
        check_code(got, model(), "all zero");
        foreach (chunk[i]) chunk[i] = 8'hFF;
        run_chunk(1'b1, got);
        check_code(got, model(), "all ones");
        foreach (chunk[i]) chunk[i] = 8'(i);
        run_chunk(1'b0, got);
        check_code(got, model(), "index pattern");
        for (int n = 0; n < 6; n++) begin
            foreach (chunk[i]) chunk[i] = 8'($urandom);
            run_chunk(n[0], got);
            check_code(got, model(), "random chunk");
        end

        // R7 / R6: after done, stray bytes do not change the held code
        exp = got;
        for (int i = 0; i < 12; i++) begin
            if (i % 3 == 0) idle_cycle();
            else            feed(8'($urandom), 1'b0);
        end
        idle_cycle();
        check(ecc_o == exp, "R7", "hold after done", 32'(ecc_o), 32'(exp));
        check(done_o == 1'b0, "R6", "no done from stray bytes", 32'(done_o), 0);

        // R9: restart in the middle of a chunk
        for (int i = 0; i < 100; i++) feed(8'($urandom), i == 0);
        foreach (chunk[i]) chunk[i] = 8'($urandom);
        run_chunk(1'b1, got);
        exp = model();
        check(got == exp, "R9", "restart mid chunk", 32'(got), 32'(exp));

        // R8: single-bit flip sweep
        foreach (chunk[i]) chunk[i] = 8'($urandom);
        run_chunk(1'b0, base);
        check_code(base, model(), "flip base");
        foreach (pos[p]) begin
            for (int b = 0; b < 8; b++) begin
                int ones;
                bit pairs_ok;
                chunk[pos[p]][b] = ~chunk[pos[p]][b];
                run_chunk(1'b0, got);
                exp = model();
                check(got == exp, "R8", "flipped chunk code", 32'(got), 32'(exp));
                d = got ^ base;
                ones = $countones(d & 24'hFCFFFF);
                pairs_ok = 1'b1;
                for (int q = 0; q < 12; q++) begin
                    if (q != 8 && (d[2*q] ^ d[2*q+1]) != 1'b1) pairs_ok = 1'b0;
                end
                check(ones == 11, "R8", "differing parity bits", 32'(ones), 11);
                check(pairs_ok, "R8", "one bit per pair", 32'(d), 32'(d));
                chunk[pos[p]][b] = ~chunk[pos[p]][b];
            end
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule